// File: doc/BRIEF.md
# Long-Duration and Periodic Interval Timer

This block is a 32-bit up-counter advanced by an external tick pulse, one tick per microsecond by default, so elapsed time is resolved to 1 µs whatever the core clock. It runs in one of two kinds of operation. The first is elapsed-time counting, in which the count climbs freely and wraps silently at its maximum. The second is a set of periodic modes, in which the count restarts from zero after a fixed number of ticks and raises an interrupt flag each time it does so.

Software reaches the timer through a small byte-wide register window. Four count bytes sit at consecutive offsets, lowest byte first, and a control byte follows them. Reading the lowest count byte freezes the whole count into a holding register, so the three upper bytes read afterwards belong to the same instant. While the timer is stopped, software can preset the count by writing the count bytes. A small state machine with the states `ST_IDLE`, `ST_ELAPSED` and `ST_PERIODIC` follows the control byte one clock later:
- it moves to `ST_IDLE` on stop, or on mode code 7;
- it moves to `ST_ELAPSED` when running with mode code 0;
- it moves to `ST_PERIODIC` when running with mode codes 1 to 6.

Each state can go directly to either of the other two.

Top module: `lpt_timer`

## Requirements
- R1: After reset the count is 0, run is 0, the mode field is 0, clock select is 0, the interrupt flag is 0 and `irq` is 0.
- R2: The register offsets are as follows. Offsets 0 to 3 hold count bits [7:0], [15:8], [23:16] and [31:24]. Offset 4 is the control byte: bit 0 is run, bits 3:1 are the mode, bit 4 is clock select, bit 7 is the interrupt flag, and bits 6:5 read as 0. Read data appears on `bus_rdata` in the clock after the clock in which `bus_rd` is sampled high.
- R3: With mode 0 and run set, the count rises by one on each selected tick. It wraps from 0xFFFFFFFF to 0 without setting the flag.
- R4: The count holds its value on ticks when run is 0, and also when the mode is 7.
- R5: Mode codes 1 to 6 give periods of 5000, 2000, 1000, 500, 200 and 100 ticks. The count runs from 0 to period−1, then the next tick returns it to 0 and sets the flag. A preset count at or above period−1 also returns to 0 and sets the flag on the next tick.
- R6: When clock select is 0, `tick_a` advances the timer. When it is 1, `tick_b` advances it. The unselected tick has no effect.
- R7: A read of offset 0 returns the live low byte and copies the whole count into the holding register. Reads of offsets 1 to 3 return holding-register bytes, which do not change until the next read of offset 0.
- R8: A write to a count byte loads that byte while the timer is in `ST_IDLE`. The write is ignored while the timer is counting.
- R9: Writing 1 to control bit 7 clears the flag, and writing 0 leaves it unchanged. A flag set in the same clock takes priority over the clear. `irq` equals the flag.
- R10: The state machine enters `ST_IDLE`, `ST_ELAPSED` or `ST_PERIODIC` one clock after the control byte selects that state. Counting follows the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_a | input | 1 | Time-base pulse selected when clock select is 0 |
| tick_b | input | 1 | Time-base pulse selected when clock select is 1 |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_rd | input | 1 | Read strobe, one clock per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request, equal to the flag |

## Verification
The embedded properties check the following on every clock:
- a counting tick adds exactly one in elapsed mode;
- the count holds when nothing steps or loads it;
- a periodic wrap lands on zero and sets the flag;
- a clear without a simultaneous set drops the flag;
- a stop sends the machine to `ST_IDLE`;
- the holding register changes only on a low-byte read.

Only the bench scenarios can show the following: the period length of each mode code, a coherent four-byte read while ticks arrive between byte reads, the tick selection, and the rejection of count writes while the timer is running.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ELAPSED  = 2'd1,
        ST_PERIODIC = 2'd2
    } lpt_state_e;

    localparam int          ADDR_W    = 3;
    localparam logic [2:0]  OFS_CTRL  = 3'd4;
    localparam int          BIT_RUN   = 0;
    localparam int          BIT_MODE  = 1;
    localparam int          MODE_W    = 3;
    localparam int          BIT_CSEL  = 4;
    localparam int          BIT_FLAG  = 7;
    localparam logic [2:0]  MODE_FREE = 3'd0;
    localparam logic [2:0]  MODE_HALT = 3'd7;

    // Rollover period in microseconds for each periodic mode code.
    function automatic int unsigned period_us(input logic [2:0] m);
        int unsigned p;
        unique case (m)
            3'd1:    p = 5000;
            3'd2:    p = 2000;
            3'd3:    p = 1000;
            3'd4:    p = 500;
            3'd5:    p = 200;
            3'd6:    p = 100;
            default: p = 1;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/lpt_fsm.sv
module lpt_fsm
    import lpt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic [2:0] mode_i,
    output lpt_state_e state_o,
    output logic       step_en_o,
    output logic       wrap_mode_o,
    output logic       loadable_o
);
    lpt_state_e state_q, state_d;
    logic       halt_req;

    assign halt_req = !run_i || (mode_i == MODE_HALT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!halt_req && mode_i == MODE_FREE)
                    state_d = ST_ELAPSED;
                else if (!halt_req)
                    state_d = ST_PERIODIC;
            end
            ST_ELAPSED: begin
                if (halt_req)
                    state_d = ST_IDLE;
                else if (mode_i != MODE_FREE)
                    state_d = ST_PERIODIC;
            end
            ST_PERIODIC: begin
                if (halt_req)
                    state_d = ST_IDLE;
                else if (mode_i == MODE_FREE)
                    state_d = ST_ELAPSED;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        step_en_o   = 1'b0;
        wrap_mode_o = 1'b0;
        loadable_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:     loadable_o = 1'b1;
            ST_ELAPSED:  step_en_o  = 1'b1;
            ST_PERIODIC: begin
                step_en_o   = 1'b1;
                wrap_mode_o = 1'b1;
            end
            default:     loadable_o = 1'b1;
        endcase
    end

    assign state_o = state_q;

    // R4 / R10: a stop request always lands in ST_IDLE next clock
    p_stop_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> state_q == ST_IDLE);

endmodule

// File: rtl/lpt_counter.sv
module lpt_counter #(
    parameter int CNT_W = 32,
    localparam int BYTES = CNT_W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             step_en_i,
    input  logic             wrap_mode_i,
    input  logic             loadable_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [BYTES-1:0] wr_byte_i,
    input  logic [7:0]       wdata_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);
    logic [CNT_W-1:0] count_q;
    logic             step;

    assign step   = tick_i && step_en_i;
    assign wrap_o = step && wrap_mode_i && (count_q >= period_i - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (step) begin
            if (wrap_o) count_q <= '0;
            else        count_q <= count_q + 1'b1;
        end else if (loadable_i) begin
            for (int b = 0; b < BYTES; b++)
                if (wr_byte_i[b]) count_q[b*8 +: 8] <= wdata_i;
        end
    end

    assign count_o = count_q;

    // R3: each counting tick in elapsed mode adds exactly one
    p_elapsed_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wrap_mode_i) |=> count_q == $past(count_q) + 1'b1);

    // R4: with no step and no load the count is frozen
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !(loadable_i && wr_byte_i != '0)) |=> $stable(count_q));

    // R5: a periodic rollover restarts from zero
    p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> count_q == '0);

endmodule

// File: rtl/lpt_ctrl.sv
module lpt_ctrl
    import lpt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctrl_i,
    input  logic       wr_run_i,
    input  logic [2:0] wr_mode_i,
    input  logic       wr_csel_i,
    input  logic       wr_flag_i,
    input  logic       set_flag_i,
    output logic       run_o,
    output logic [2:0] mode_o,
    output logic       csel_o,
    output logic       flag_o
);
    logic       run_q, csel_q, flag_q;
    logic [2:0] mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            mode_q <= MODE_FREE;
            csel_q <= 1'b0;
        end else if (wr_ctrl_i) begin
            run_q  <= wr_run_i;
            mode_q <= wr_mode_i;
            csel_q <= wr_csel_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        flag_q <= 1'b0;
        else if (set_flag_i)               flag_q <= 1'b1;
        else if (wr_ctrl_i && wr_flag_i)   flag_q <= 1'b0;
    end

    assign run_o  = run_q;
    assign mode_o = mode_q;
    assign csel_o = csel_q;
    assign flag_o = flag_q;

    // R5: a rollover always leaves the flag set
    p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_flag_i |=> flag_q);

    // R9: write-one clears when no rollover competes
    p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl_i && wr_flag_i && !set_flag_i) |=> !flag_q);

endmodule

// File: rtl/lpt_readback.sv
module lpt_readback
    import lpt_pkg::*;
#(
    parameter int CNT_W = 32,
    localparam int BYTES = CNT_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [7:0]        ctrl_i,
    output logic [7:0]        rdata_o
);
    logic [CNT_W-1:0] hold_q;
    logic [7:0]       rdata_q;
    logic             snap;

    assign snap = rd_i && (addr_i == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    hold_q <= '0;
        else if (snap) hold_q <= count_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_i) begin
            if (snap)
                rdata_q <= count_i[7:0];
            else if (int'(addr_i) < BYTES)
                rdata_q <= hold_q[int'(addr_i)*8 +: 8];
            else if (addr_i == OFS_CTRL)
                rdata_q <= ctrl_i;
            else
                rdata_q <= '0;
        end
    end

    assign rdata_o = rdata_q;

    // R7: the holding copy changes only on a low-byte read
    p_hold_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !snap |=> $stable(hold_q));

endmodule

// File: rtl/lpt_timer.sv
module lpt_timer
    import lpt_pkg::*;
#(
    parameter int CNT_W        = 32,
    parameter int TICKS_PER_US = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_a,
    input  logic              tick_b,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq
);
    localparam int BYTES = CNT_W / 8;

    logic             run, csel, flag, tick_sel, wrap;
    logic [2:0]       mode;
    logic             step_en, wrap_mode, loadable;
    lpt_state_e       state;
    logic [CNT_W-1:0] count, period;
    logic [BYTES-1:0] wr_byte;
    logic             wr_ctrl;
    logic [7:0]       ctrl_byte;
    logic             lint_unused_bits;

    assign lint_unused_bits = ^{bus_wdata[6:5], state};
    assign wr_ctrl  = bus_wr && (bus_addr == OFS_CTRL);
    assign tick_sel = csel ? tick_b : tick_a;
    assign period   = CNT_W'(period_us(mode) * TICKS_PER_US);

    for (genvar b = 0; b < BYTES; b++) begin : g_wr_dec
        assign wr_byte[b] = bus_wr && (int'(bus_addr) == b);
    end

    always_comb begin
        ctrl_byte                        = '0;
        ctrl_byte[BIT_RUN]               = run;
        ctrl_byte[BIT_MODE +: MODE_W]    = mode;
        ctrl_byte[BIT_CSEL]              = csel;
        ctrl_byte[BIT_FLAG]              = flag;
    end

    lpt_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl_i  (wr_ctrl),
        .wr_run_i   (bus_wdata[BIT_RUN]),
        .wr_mode_i  (bus_wdata[BIT_MODE +: MODE_W]),
        .wr_csel_i  (bus_wdata[BIT_CSEL]),
        .wr_flag_i  (bus_wdata[BIT_FLAG]),
        .set_flag_i (wrap),
        .run_o      (run),
        .mode_o     (mode),
        .csel_o     (csel),
        .flag_o     (flag)
    );

    lpt_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run),
        .mode_i      (mode),
        .state_o     (state),
        .step_en_o   (step_en),
        .wrap_mode_o (wrap_mode),
        .loadable_o  (loadable)
    );

    lpt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_sel),
        .step_en_i   (step_en),
        .wrap_mode_i (wrap_mode),
        .loadable_i  (loadable),
        .period_i    (period),
        .wr_byte_i   (wr_byte),
        .wdata_i     (bus_wdata),
        .count_o     (count),
        .wrap_o      (wrap)
    );

    lpt_readback #(.CNT_W(CNT_W)) u_readback (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_i    (bus_rd),
        .addr_i  (bus_addr),
        .count_i (count),
        .ctrl_i  (ctrl_byte),
        .rdata_o (bus_rdata)
    );

    assign irq = flag;

    // R6: a pulse on the unselected tick alone never moves the count
    p_tick_select_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_sel && !bus_wr) |=> $stable(count));

endmodule

// File: tb/lpt_timer_tb_top.sv
module lpt_timer_tb_top;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_a = 1'b0, tick_b = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    lpt_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    localparam int NV = 8;
    localparam int VT_MODE [NV] = '{0, 6, 6, 5, 4, 7, 3, 2};
    localparam int VT_TICKS[NV] = '{7, 100, 150, 199, 500, 30, 1001, 2000};
    localparam int VT_EXP  [NV] = '{7, 0, 50, 199, 0, 0, 1, 0};
    localparam int VT_FLAG [NV] = '{0, 1, 1, 0, 1, 0, 1, 1};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic ctl(input logic clr, input logic cs, input logic [2:0] m, input logic run);
        wr(3'd4, {clr, 2'b00, cs, m, run});
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic ticks(input int n, input bit use_b);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (use_b) tick_b = 1'b1; else tick_a = 1'b1;
            @(negedge clk);
            tick_a = 1'b0; tick_b = 1'b0;
        end
    endtask

    task automatic read32(output logic [31:0] v);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin
            rd(3'(i), b);
            v[i*8 +: 8] = b;
        end
    endtask

    task automatic load32(input logic [31:0] v);
        for (int i = 0; i < 4; i++) wr(3'(i), v[i*8 +: 8]);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        read32(v);       check("R1 count after reset", v, 32'h0);
        rd(3'd4, b);     check("R1 control after reset", {24'h0, b}, 32'h0);
        check("R1 irq after reset", {31'h0, irq}, 32'h0);

        // Vector table: R3 R4 R5 R10 across mode codes
        for (int k = 0; k < NV; k++) begin
            ctl(1'b1, 1'b0, 3'd0, 1'b0);
            load32(32'h0);
            ctl(1'b1, 1'b0, 3'(VT_MODE[k]), 1'b1);
            ticks(VT_TICKS[k], 1'b0);
            read32(v);
            check($sformatf("R5 R3 R4 vector %0d count", k), v, 32'(VT_EXP[k]));
            rd(3'd4, b);
            check($sformatf("R5 R9 vector %0d flag", k), {31'h0, b[7]}, 32'(VT_FLAG[k]));
            check($sformatf("R9 vector %0d irq", k), {31'h0, irq}, 32'(VT_FLAG[k]));
        end

        // R2: control field positions read back, reserved bits zero
        ctl(1'b1, 1'b1, 3'd5, 1'b0);
        rd(3'd4, b);     check("R2 control readback", {24'h0, b}, 32'h1A);

        // R8: load while stopped, R2 byte order
        ctl(1'b1, 1'b0, 3'd0, 1'b0);
        load32(32'h1234_5678);
        read32(v);       check("R8 R2 stopped load", v, 32'h1234_5678);

        // R8: write while running ignored
        ctl(1'b0, 1'b0, 3'd0, 1'b1);
        wr(3'd0, 8'hAA); wr(3'd3, 8'h55);
        read32(v);       check("R8 running write ignored", v, 32'h1234_5678);

        // R4: run=0 holds count
        ctl(1'b0, 1'b0, 3'd0, 1'b0);
        ticks(5, 1'b0);
        read32(v);       check("R4 stopped hold", v, 32'h1234_5678);

        // R3: elapsed wrap without flag
        ctl(1'b1, 1'b0, 3'd0, 1'b0);
        load32(32'hFFFF_FFFE);
        ctl(1'b0, 1'b0, 3'd0, 1'b1);
        ticks(3, 1'b0);
        read32(v);       check("R3 elapsed wrap", v, 32'h1);
        check("R3 no flag on wrap", {31'h0, irq}, 32'h0);

        // R7: coherent snapshot, hold survives ticks
        ctl(1'b0, 1'b0, 3'd0, 1'b0);
        load32(32'h0000_00FF);
        ctl(1'b0, 1'b0, 3'd0, 1'b1);
        rd(3'd0, b);     check("R7 live low byte", {24'h0, b}, 32'hFF);
        ticks(1, 1'b0);
        rd(3'd1, b);     check("R7 hold byte1 stale", {24'h0, b}, 32'h0);
        read32(v);       check("R7 new snapshot", v, 32'h100);

        // R6: clock select
        ctl(1'b0, 1'b1, 3'd0, 1'b0);
        load32(32'h0);
        ctl(1'b0, 1'b1, 3'd0, 1'b1);
        ticks(5, 1'b0);
        read32(v);       check("R6 tick_a ignored when csel=1", v, 32'h0);
        ticks(3, 1'b1);
        read32(v);       check("R6 tick_b counts when csel=1", v, 32'h3);
        ctl(1'b0, 1'b0, 3'd0, 1'b1);
        ticks(2, 1'b1);
        read32(v);       check("R6 tick_b ignored when csel=0", v, 32'h3);

        // R5: preset near and above the period
        ctl(1'b1, 1'b0, 3'd0, 1'b0);
        load32(32'd4998);
        ctl(1'b1, 1'b0, 3'd1, 1'b1);
        ticks(1, 1'b0);
        read32(v);       check("R5 5000 period before wrap", v, 32'd4999);
        check("R5 no flag before wrap", {31'h0, irq}, 32'h0);
        ticks(1, 1'b0);
        read32(v);       check("R5 5000 period wrap", v, 32'h0);
        check("R5 flag at wrap", {31'h0, irq}, 32'h1);
        ctl(1'b1, 1'b0, 3'd0, 1'b0);
        load32(32'd6000);
        ctl(1'b1, 1'b0, 3'd6, 1'b1);
        ticks(1, 1'b0);
        read32(v);       check("R5 preset above period wraps", v, 32'h0);

        // R9: write-0 keeps flag, write-1 clears
        ctl(1'b0, 1'b0, 3'd0, 1'b0);
        check("R9 flag kept by write 0", {31'h0, irq}, 32'h1);
        ctl(1'b1, 1'b0, 3'd0, 1'b0);
        check("R9 flag cleared by write 1", {31'h0, irq}, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule